// File: doc/BRIEF.md
# Dual-Port RAM with Mailbox Interrupts

This block is a synchronous true dual-port RAM, 4096 words of 16 bits by default, with two identical ports, A and B. Either port can read or write any location in any cycle. Every control input is active low: chip select, output enable and write enable. Read data appears one clock after the access.

The two highest addresses also act as mailboxes between the ports. The second-highest address (0xFFE by default) is port A's mailbox. A write to it by port B raises port A's interrupt. The highest address (0xFFF) is port B's mailbox. A write to it by port A raises port B's interrupt. The receiving port acknowledges the interrupt by accessing its own mailbox with chip select and output enable both low. The message word itself is stored as ordinary RAM.

When `mbox_en` is low, both mailbox words are plain memory and the interrupt flags hold their value. Arbitration of simultaneous accesses to the same word is not part of this block.

Top module: `dpram_mailbox`

## Requirements
- R1: A word written by a port (chip select and write enable low) is returned on that port's read data one clock after a later read of the same address. A read is chip select low, write enable high and output enable low.
- R2: A word written by one port is returned to the other port by a read of that address, also one clock after the read.
- R3: With `mbox_en` high, a port B write to address 2^AW-2 drives `a_irq_n` low from the next clock.
- R4: With `mbox_en` high, a port A write to address 2^AW-1 drives `b_irq_n` low from the next clock.
- R5: With `mbox_en` high, a port that accesses its own mailbox with chip select and output enable both low releases its interrupt to high on the next clock, whatever the level of write enable. The message written to a mailbox is read back like any other word.
- R6: When one cycle both raises and acknowledges the same flag, the flag ends up asserted.
- R7: With `mbox_en` low, neither interrupt output changes, and the mailbox addresses behave as plain RAM.
- R8: A port writing its own mailbox with output enable high leaves its own interrupt unchanged. An access with chip select high does not acknowledge a flag.
- R9: After reset, both interrupt outputs are high and both read data outputs are zero.
- R10: A port's read data holds its value in every cycle that is not a read on that port, including a read attempt with output enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mbox_en | input | 1 | Mailbox interrupt function enable |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_we_n | input | 1 | Port A write enable, active low |
| a_addr | input | AW | Port A address |
| a_wdata | input | DW | Port A write data |
| a_rdata | output | DW | Port A registered read data |
| a_irq_n | output | 1 | Port A interrupt, active low |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_we_n | input | 1 | Port B write enable, active low |
| b_addr | input | AW | Port B address |
| b_wdata | input | DW | Port B write data |
| b_rdata | output | DW | Port B registered read data |
| b_irq_n | output | 1 | Port B interrupt, active low |

## Verification
The bench sweeps every address of a 16-word, 8-bit instance from each port in turn, first with the mailboxes disabled. A design that decoded the mailbox addresses, or lost writes near the top of memory, would return wrong data or move an interrupt during this sweep.

It then targets the following cases:
- a cycle that both raises and acknowledges a flag, which a clear-priority design would leave released;
- an acknowledge made with write enable low, which a design needing a pure read would ignore;
- a port writing its own mailbox with output enable high, which an address-only decode would treat as an acknowledge;
- an access with chip select high, which a design that ignored chip select would treat as an acknowledge;
- toggling `mbox_en` while a flag is pending, which a design that kept updating flags while disabled would release.

A read attempt with output enable high is checked to leave the read data unchanged.

// File: rtl/dpram_mailbox.sv
module dpram_mailbox #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mbox_en,
  input  logic          a_cs_n,
  input  logic          a_oe_n,
  input  logic          a_we_n,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_irq_n,
  input  logic          b_cs_n,
  input  logic          b_oe_n,
  input  logic          b_we_n,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_irq_n
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] BOX_A = AW'(DEPTH - 2);
  localparam logic [AW-1:0] BOX_B = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic flag_a, flag_b;

  wire a_wr = !a_cs_n && !a_we_n;
  wire b_wr = !b_cs_n && !b_we_n;
  wire a_rd = !a_cs_n && a_we_n && !a_oe_n;
  wire b_rd = !b_cs_n && b_we_n && !b_oe_n;

  wire set_a = mbox_en && b_wr && (b_addr == BOX_A);
  wire set_b = mbox_en && a_wr && (a_addr == BOX_B);
  wire ack_a = mbox_en && !a_cs_n && !a_oe_n && (a_addr == BOX_A);
  wire ack_b = mbox_en && !b_cs_n && !b_oe_n && (b_addr == BOX_B);

  always_ff @(posedge clk) begin
    if (a_wr) mem[a_addr] <= a_wdata;
    if (b_wr) mem[b_addr] <= b_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rdata <= '0;
      b_rdata <= '0;
    end else begin
      if (a_rd) a_rdata <= mem[a_addr];
      if (b_rd) b_rdata <= mem[b_addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_a <= 1'b0;
      flag_b <= 1'b0;
    end else begin
      if (set_a)      flag_a <= 1'b1;
      else if (ack_a) flag_a <= 1'b0;
      if (set_b)      flag_b <= 1'b1;
      else if (ack_b) flag_b <= 1'b0;
    end
  end

  assign a_irq_n = !flag_a;
  assign b_irq_n = !flag_b;

  a_r3_set_a: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_en && !b_cs_n && !b_we_n && b_addr == BOX_A) |=> !a_irq_n);
  a_r4_set_b: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_en && !a_cs_n && !a_we_n && a_addr == BOX_B) |=> !b_irq_n);
  a_r5_ack_a: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_en && !a_cs_n && !a_oe_n && a_addr == BOX_A &&
     !(!b_cs_n && !b_we_n && b_addr == BOX_A)) |=> a_irq_n);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mbox_en |=> ($stable(a_irq_n) && $stable(b_irq_n)));
  a_r8_cs_a: assert property (@(posedge clk) disable iff (!rst_n)
    (a_cs_n && !(mbox_en && !b_cs_n && !b_we_n && b_addr == BOX_A)) |=> $stable(a_irq_n));
  a_r10_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
    !(!a_cs_n && a_we_n && !a_oe_n) |=> $stable(a_rdata));
  a_r10_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
    !(!b_cs_n && b_we_n && !b_oe_n) |=> $stable(b_rdata));
endmodule

// File: tb/dpram_mailbox_tb.sv
module dpram_mailbox_tb;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int N = 1 << AW;
  localparam logic [AW-1:0] BA = AW'(N - 2);
  localparam logic [AW-1:0] BB = AW'(N - 1);

  logic clk = 1'b0, rst_n = 1'b0, mbox_en = 1'b0;
  logic a_cs_n = 1, a_oe_n = 1, a_we_n = 1, b_cs_n = 1, b_oe_n = 1, b_we_n = 1;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic [DW-1:0] a_rdata, b_rdata;
  logic a_irq_n, b_irq_n;
  int total = 0, bad = 0;
  bit done = 0;

  dpram_mailbox #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mbox_en(mbox_en),
    .a_cs_n(a_cs_n), .a_oe_n(a_oe_n), .a_we_n(a_we_n), .a_addr(a_addr),
    .a_wdata(a_wdata), .a_rdata(a_rdata), .a_irq_n(a_irq_n),
    .b_cs_n(b_cs_n), .b_oe_n(b_oe_n), .b_we_n(b_we_n), .b_addr(b_addr),
    .b_wdata(b_wdata), .b_rdata(b_rdata), .b_irq_n(b_irq_n));

  always #10 clk = ~clk;

  function automatic logic [DW-1:0] pa(int i); return DW'(i * 37 + 5); endfunction
  function automatic logic [DW-1:0] pb(int i); return DW'(i * 91 + 200); endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    a_cs_n = 1; a_oe_n = 1; a_we_n = 1;
    b_cs_n = 1; b_oe_n = 1; b_we_n = 1;
  endtask

  task automatic aop(logic cs, logic oe, logic we, logic [AW-1:0] ad, logic [DW-1:0] d);
    a_cs_n = cs; a_oe_n = oe; a_we_n = we; a_addr = ad; a_wdata = d;
  endtask
  task automatic bop(logic cs, logic oe, logic we, logic [AW-1:0] ad, logic [DW-1:0] d);
    b_cs_n = cs; b_oe_n = oe; b_we_n = we; b_addr = ad; b_wdata = d;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R9 a_irq_n", DW'(a_irq_n), DW'(1));
    chk("R9 b_irq_n", DW'(b_irq_n), DW'(1));
    chk("R9 a_rdata", a_rdata, '0);
    chk("R9 b_rdata", b_rdata, '0);
    rst_n = 1;
    step();

    for (int i = 0; i < N; i++) begin aop(0, 1, 0, AW'(i), pa(i)); step(); end
    for (int i = 0; i < N; i++) begin
      aop(0, 0, 1, AW'(i), '0); step();
      chk("R1 a readback", a_rdata, pa(i));
    end
    for (int i = 0; i < N; i++) begin
      bop(0, 0, 1, AW'(i), '0); step();
      chk("R2 b reads a", b_rdata, pa(i));
    end
    for (int i = 0; i < N; i++) begin bop(0, 1, 0, AW'(i), pb(i)); step(); end
    for (int i = 0; i < N; i++) begin
      bop(0, 0, 1, AW'(i), '0); step();
      chk("R1 b readback", b_rdata, pb(i));
    end
    for (int i = 0; i < N; i++) begin
      aop(0, 0, 1, AW'(i), '0); step();
      chk("R2 a reads b", a_rdata, pb(i));
    end
    chk("R7 a_irq_n disabled", DW'(a_irq_n), DW'(1));
    chk("R7 b_irq_n disabled", DW'(b_irq_n), DW'(1));

    mbox_en = 1;
    bop(0, 1, 0, BA, 8'h5A); step();
    chk("R3 a_irq_n set", DW'(a_irq_n), DW'(0));
    chk("R3 b_irq_n quiet", DW'(b_irq_n), DW'(1));
    aop(0, 0, 1, BA, '0); step();
    chk("R5 message", a_rdata, 8'h5A);
    chk("R5 a ack", DW'(a_irq_n), DW'(1));

    aop(0, 1, 0, BB, 8'hC3); step();
    chk("R4 b_irq_n set", DW'(b_irq_n), DW'(0));
    chk("R4 a_irq_n quiet", DW'(a_irq_n), DW'(1));
    bop(0, 0, 0, BB, 8'h33); step();
    chk("R5 b ack with write", DW'(b_irq_n), DW'(1));
    bop(0, 0, 1, BB, '0); step();
    chk("R5 b mailbox data", b_rdata, 8'h33);

    bop(0, 1, 0, BA, 8'h11); step();
    aop(0, 1, 0, BA, 8'h22); step();
    chk("R8 own write oe high", DW'(a_irq_n), DW'(0));
    aop(1, 0, 1, BA, '0); step();
    chk("R8 cs high no ack", DW'(a_irq_n), DW'(0));
    chk("R10 no read hold", a_rdata, 8'h5A);
    aop(0, 1, 1, 4'h3, '0); step();
    chk("R10 oe high hold", a_rdata, 8'h5A);
    aop(0, 0, 1, BA, '0); step();
    chk("R5 ack after R8", DW'(a_irq_n), DW'(1));
    chk("R8 own write stored", a_rdata, 8'h22);

    bop(0, 1, 0, BA, 8'h44); aop(0, 0, 1, BA, '0); step();
    chk("R6 set wins", DW'(a_irq_n), DW'(0));
    aop(0, 0, 1, BA, '0); step();
    chk("R6 later ack", DW'(a_irq_n), DW'(1));

    bop(0, 1, 0, BA, 8'h66); step();
    mbox_en = 0;
    aop(0, 0, 1, BA, '0); step();
    chk("R7 no ack disabled", DW'(a_irq_n), DW'(0));
    chk("R7 plain read", a_rdata, 8'h66);
    aop(0, 1, 0, BB, 8'h77); step();
    chk("R7 no set disabled", DW'(b_irq_n), DW'(1));
    mbox_en = 1;
    aop(0, 0, 1, BA, '0); step();
    chk("R5 ack re-enabled", DW'(a_irq_n), DW'(1));

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule